// File: doc/BRIEF.md
# Trap Argument Writeback Sequencer

This block runs once per trap entry as the tail of a hardware context push. When started while idle, it captures the trap context at the start edge: the cause, the three fault-detail values, their update flags, the top-interrupt and top-external-interrupt CSR values, the stack pointer, the saved PC and the previous interrupt status. It then issues stack stores and argument-register writes, one per cycle. The store port saves the interrupted PC and the previous interrupt status at fixed offsets from the stack pointer. The register-file write port then fills argument registers x10 (a0) to x13 (a1..a3), with contents chosen by the class of the trap. The last step is a one-cycle pulse that sets the interrupt-enable bit in the status register, together with a done pulse.

A trap is a synchronous exception when the most significant bit of the cause is clear. Otherwise it is an interrupt. An interrupt identity is the CSR value shifted right by `ID_SHIFT` (16), so the identity field ends up at bit 0. An interrupt whose major identity equals `EXT_MAJOR` (11) is external. It writes the major identity to a0 and the minor identity to a1. Any other interrupt writes only its major identity to a0.

The state machine has these states:
- `S_IDLE`: waiting for a start.
- `S_PUSH_PC`: store the saved PC.
- `S_PUSH_ST`: store the previous interrupt status.
- `S_ARG0` to `S_ARG3`: write a0 to a3.
- `S_FINISH`: pulse interrupt-enable and done.

The transitions are:
- `S_IDLE` goes to `S_PUSH_PC` on start.
- `S_PUSH_PC` goes to `S_PUSH_ST`, which goes to `S_ARG0`.
- From `S_ARG0`, an exception goes to the first of `S_ARG1`/`S_ARG2`/`S_ARG3` whose flag is set, or to `S_FINISH` if none is set. An external interrupt goes to `S_ARG1`. Any other interrupt goes to `S_FINISH`.
- From `S_ARG1`, an exception goes to the next flagged state or to `S_FINISH`. An external interrupt goes to `S_FINISH`.
- From `S_ARG2`, the next state is `S_ARG3` if its flag is set, else `S_FINISH`.
- `S_ARG3` goes to `S_FINISH`, and `S_FINISH` goes to `S_IDLE`.

Top module: `trap_argwb_seq`

## Requirements
- R1: During and right after reset, no store, no register write, no interrupt-enable pulse and no done is asserted.
- R2: A start seen at a clock edge while idle is accepted. In the next cycle the saved PC is stored at sp+24. In the cycle after that, the previous interrupt status is stored at sp+28. All values used by the sequence are those present at the accepting edge, and later input changes have no effect on it.
- R3: For an exception (cause bit DW-1 clear), the cycle after the status store writes x10 with the cause. Then x11 gets the fault value, x12 the second fault value and x13 the trapped instruction, in that order. Each of these three writes happens only if its update flag was set, and a skipped write takes no cycle.
- R4: A cause with bit DW-1 set is handled as an interrupt, whatever its other bits are.
- R5: For an interrupt whose major identity (top-interrupt value >> 16) differs from 11, only x10 is written, with the major identity.
- R6: For an interrupt whose major identity equals 11, x10 is written with the major identity and then x11 with the minor identity (top-external-interrupt value >> 16). x12 and x13 are not written.
- R7: In the cycle after the last register write, the interrupt-enable set pulse and done are high together for exactly one cycle. The block is then idle.
- R8: In any cycle there is at most one stack store or one register write, never both.
- R9: A start while the sequence is running is ignored and does not restart or change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (taken only when idle) |
| cause_i | input | DW | Trap cause value |
| tval_i | input | DW | Fault value |
| tval2_i | input | DW | Second fault value |
| tinst_i | input | DW | Trapped instruction value |
| tval_wr_i | input | 1 | Fault value was updated by this exception |
| tval2_wr_i | input | 1 | Second fault value was updated |
| tinst_wr_i | input | 1 | Trapped instruction value was updated |
| topi_i | input | DW | Top-interrupt CSR value |
| topei_i | input | DW | Top-external-interrupt CSR value |
| sp_i | input | DW | Stack pointer |
| epc_i | input | DW | Saved PC of the interrupted context |
| pistatus_i | input | DW | Previous interrupt status |
| rf_we_o | output | 1 | Register-file write enable |
| rf_addr_o | output | 5 | Register-file write address |
| rf_data_o | output | DW | Register-file write data |
| st_en_o | output | 1 | Stack store request |
| st_addr_o | output | DW | Stack store address |
| st_data_o | output | DW | Stack store data |
| ie_set_o | output | 1 | Set interrupt-enable in the status register |
| done_o | output | 1 | Sequence complete |

## Verification
On every cycle, assertions check several properties:
- A store and a register write never happen together.
- Done never lasts two cycles.
- A non-external interrupt writes only x10.
- An external interrupt writes only x10 and x11.
- An exception writes x11 only when the fault-value flag is set.
- A start while busy never re-enters the first push state.

Other behaviour can only be shown by the bench's scenarios:
- The exact order and timing of stores and writes.
- The data values, including the dropped low 16 bits of the interrupt CSRs.
- The sign-bit boundary of the cause.
- That inputs changed and starts pulsed mid-sequence leave the sequence unchanged.

// File: rtl/trap_argwb_pkg.sv
package trap_argwb_pkg;

    typedef enum logic [1:0] {
        CLS_EXC,
        CLS_MAJ,
        CLS_EXT
    } trap_cls_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_PC,
        S_PUSH_ST,
        S_ARG0,
        S_ARG1,
        S_ARG2,
        S_ARG3,
        S_FINISH
    } seq_state_e;

    // First argument register (x10); a1..a3 follow consecutively.
    localparam logic [4:0] ARG_REG_BASE = 5'd10;

endpackage

// File: rtl/trap_ctx_latch.sv
module trap_ctx_latch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] cause_i,
    input  logic [DW-1:0] tval_i,
    input  logic [DW-1:0] tval2_i,
    input  logic [DW-1:0] tinst_i,
    input  logic          tval_wr_i,
    input  logic          tval2_wr_i,
    input  logic          tinst_wr_i,
    input  logic [DW-1:0] topi_i,
    input  logic [DW-1:0] topei_i,
    input  logic [DW-1:0] sp_i,
    input  logic [DW-1:0] epc_i,
    input  logic [DW-1:0] pistatus_i,
    output logic [DW-1:0] cause_q,
    output logic [DW-1:0] tval_q,
    output logic [DW-1:0] tval2_q,
    output logic [DW-1:0] tinst_q,
    output logic          tval_wr_q,
    output logic          tval2_wr_q,
    output logic          tinst_wr_q,
    output logic [DW-1:0] topi_q,
    output logic [DW-1:0] topei_q,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] epc_q,
    output logic [DW-1:0] pistatus_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q    <= '0;
            tval_q     <= '0;
            tval2_q    <= '0;
            tinst_q    <= '0;
            tval_wr_q  <= 1'b0;
            tval2_wr_q <= 1'b0;
            tinst_wr_q <= 1'b0;
            topi_q     <= '0;
            topei_q    <= '0;
            sp_q       <= '0;
            epc_q      <= '0;
            pistatus_q <= '0;
        end else if (load_i) begin
            cause_q    <= cause_i;
            tval_q     <= tval_i;
            tval2_q    <= tval2_i;
            tinst_q    <= tinst_i;
            tval_wr_q  <= tval_wr_i;
            tval2_wr_q <= tval2_wr_i;
            tinst_wr_q <= tinst_wr_i;
            topi_q     <= topi_i;
            topei_q    <= topei_i;
            sp_q       <= sp_i;
            epc_q      <= epc_i;
            pistatus_q <= pistatus_i;
        end
    end

endmodule

// File: rtl/trap_classify.sv
module trap_classify
    import trap_argwb_pkg::*;
#(
    parameter int DW        = 32,
    parameter int ID_SHIFT  = 16,
    parameter int EXT_MAJOR = 11
) (
    input  logic [DW-1:0] cause_i,
    input  logic [DW-1:0] topi_i,
    input  logic [DW-1:0] topei_i,
    output trap_cls_e     cls_o,
    output logic [DW-1:0] major_o,
    output logic [DW-1:0] minor_o
);

    localparam logic [DW-1:0] EXT_ID = DW'(EXT_MAJOR);

    always_comb begin
        major_o = topi_i >> ID_SHIFT;
        minor_o = topei_i >> ID_SHIFT;
        if (!cause_i[DW-1]) begin
            cls_o = CLS_EXC;
        end else if (major_o == EXT_ID) begin
            cls_o = CLS_EXT;
        end else begin
            cls_o = CLS_MAJ;
        end
    end

endmodule

// File: rtl/trap_wb_fsm.sv
module trap_wb_fsm
    import trap_argwb_pkg::*;
#(
    parameter int DW      = 32,
    parameter int EPC_OFS = 24,
    parameter int PIS_OFS = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  trap_cls_e     cls_i,
    input  logic [DW-1:0] cause_i,
    input  logic [DW-1:0] major_i,
    input  logic [DW-1:0] minor_i,
    input  logic [DW-1:0] tval_i,
    input  logic [DW-1:0] tval2_i,
    input  logic [DW-1:0] tinst_i,
    input  logic          tval_wr_i,
    input  logic          tval2_wr_i,
    input  logic          tinst_wr_i,
    input  logic [DW-1:0] sp_i,
    input  logic [DW-1:0] epc_i,
    input  logic [DW-1:0] pistatus_i,
    output logic          load_o,
    output logic          rf_we_o,
    output logic [4:0]    rf_addr_o,
    output logic [DW-1:0] rf_data_o,
    output logic          st_en_o,
    output logic [DW-1:0] st_addr_o,
    output logic [DW-1:0] st_data_o,
    output logic          ie_set_o,
    output logic          done_o
);

    localparam logic [DW-1:0] EPC_OFS_V = DW'(EPC_OFS);
    localparam logic [DW-1:0] PIS_OFS_V = DW'(PIS_OFS);

    seq_state_e state_q, state_d;

    assign load_o = (state_q == S_IDLE) && start_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_PUSH_PC;
            S_PUSH_PC: state_d = S_PUSH_ST;
            S_PUSH_ST: state_d = S_ARG0;
            S_ARG0: begin
                if (cls_i == CLS_EXC) begin
                    if (tval_wr_i)       state_d = S_ARG1;
                    else if (tval2_wr_i) state_d = S_ARG2;
                    else if (tinst_wr_i) state_d = S_ARG3;
                    else                 state_d = S_FINISH;
                end else if (cls_i == CLS_EXT) begin
                    state_d = S_ARG1;
                end else begin
                    state_d = S_FINISH;
                end
            end
            S_ARG1: begin
                if (cls_i == CLS_EXC && tval2_wr_i)      state_d = S_ARG2;
                else if (cls_i == CLS_EXC && tinst_wr_i) state_d = S_ARG3;
                else                                     state_d = S_FINISH;
            end
            S_ARG2:   state_d = tinst_wr_i ? S_ARG3 : S_FINISH;
            S_ARG3:   state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        rf_we_o   = 1'b0;
        rf_addr_o = '0;
        rf_data_o = '0;
        st_en_o   = 1'b0;
        st_addr_o = '0;
        st_data_o = '0;
        ie_set_o  = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PUSH_PC: begin
                st_en_o   = 1'b1;
                st_addr_o = sp_i + EPC_OFS_V;
                st_data_o = epc_i;
            end
            S_PUSH_ST: begin
                st_en_o   = 1'b1;
                st_addr_o = sp_i + PIS_OFS_V;
                st_data_o = pistatus_i;
            end
            S_ARG0: begin
                rf_we_o   = 1'b1;
                rf_addr_o = ARG_REG_BASE;
                rf_data_o = (cls_i == CLS_EXC) ? cause_i : major_i;
            end
            S_ARG1: begin
                rf_we_o   = 1'b1;
                rf_addr_o = ARG_REG_BASE + 5'd1;
                rf_data_o = (cls_i == CLS_EXC) ? tval_i : minor_i;
            end
            S_ARG2: begin
                rf_we_o   = 1'b1;
                rf_addr_o = ARG_REG_BASE + 5'd2;
                rf_data_o = tval2_i;
            end
            S_ARG3: begin
                rf_we_o   = 1'b1;
                rf_addr_o = ARG_REG_BASE + 5'd3;
                rf_data_o = tinst_i;
            end
            S_FINISH: begin
                ie_set_o = 1'b1;
                done_o   = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: one port active per cycle
    assert_single_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we_o && st_en_o));

    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: non-external interrupt writes a0 only
    assert_major_a0_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && cls_i == CLS_MAJ) |-> (rf_addr_o == ARG_REG_BASE));

    // R6: external interrupt writes a0 and a1 only
    assert_ext_a0_a1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && cls_i == CLS_EXT) |->
            (rf_addr_o == ARG_REG_BASE || rf_addr_o == ARG_REG_BASE + 5'd1));

    // R3: exception writes a1 only when the fault value was updated
    assert_exc_a1_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && cls_i == CLS_EXC && rf_addr_o == ARG_REG_BASE + 5'd1) |-> tval_wr_i);

    // R9: start while busy never restarts the sequence
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start_i) |=> (state_q != S_PUSH_PC));

endmodule

// File: rtl/trap_argwb_seq.sv
module trap_argwb_seq
    import trap_argwb_pkg::*;
#(
    parameter int DW        = 32,
    parameter int ID_SHIFT  = 16,
    parameter int EXT_MAJOR = 11,
    parameter int EPC_OFS   = 24,
    parameter int PIS_OFS   = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] cause_i,
    input  logic [DW-1:0] tval_i,
    input  logic [DW-1:0] tval2_i,
    input  logic [DW-1:0] tinst_i,
    input  logic          tval_wr_i,
    input  logic          tval2_wr_i,
    input  logic          tinst_wr_i,
    input  logic [DW-1:0] topi_i,
    input  logic [DW-1:0] topei_i,
    input  logic [DW-1:0] sp_i,
    input  logic [DW-1:0] epc_i,
    input  logic [DW-1:0] pistatus_i,
    output logic          rf_we_o,
    output logic [4:0]    rf_addr_o,
    output logic [DW-1:0] rf_data_o,
    output logic          st_en_o,
    output logic [DW-1:0] st_addr_o,
    output logic [DW-1:0] st_data_o,
    output logic          ie_set_o,
    output logic          done_o
);

    logic          load;
    logic [DW-1:0] cause_q, tval_q, tval2_q, tinst_q;
    logic          tval_wr_q, tval2_wr_q, tinst_wr_q;
    logic [DW-1:0] topi_q, topei_q, sp_q, epc_q, pistatus_q;
    trap_cls_e     cls;
    logic [DW-1:0] major, minor;

    trap_ctx_latch #(.DW(DW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .cause_i    (cause_i),
        .tval_i     (tval_i),
        .tval2_i    (tval2_i),
        .tinst_i    (tinst_i),
        .tval_wr_i  (tval_wr_i),
        .tval2_wr_i (tval2_wr_i),
        .tinst_wr_i (tinst_wr_i),
        .topi_i     (topi_i),
        .topei_i    (topei_i),
        .sp_i       (sp_i),
        .epc_i      (epc_i),
        .pistatus_i (pistatus_i),
        .cause_q    (cause_q),
        .tval_q     (tval_q),
        .tval2_q    (tval2_q),
        .tinst_q    (tinst_q),
        .tval_wr_q  (tval_wr_q),
        .tval2_wr_q (tval2_wr_q),
        .tinst_wr_q (tinst_wr_q),
        .topi_q     (topi_q),
        .topei_q    (topei_q),
        .sp_q       (sp_q),
        .epc_q      (epc_q),
        .pistatus_q (pistatus_q)
    );

    trap_classify #(
        .DW        (DW),
        .ID_SHIFT  (ID_SHIFT),
        .EXT_MAJOR (EXT_MAJOR)
    ) u_classify (
        .cause_i (cause_q),
        .topi_i  (topi_q),
        .topei_i (topei_q),
        .cls_o   (cls),
        .major_o (major),
        .minor_o (minor)
    );

    trap_wb_fsm #(
        .DW      (DW),
        .EPC_OFS (EPC_OFS),
        .PIS_OFS (PIS_OFS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cls_i      (cls),
        .cause_i    (cause_q),
        .major_i    (major),
        .minor_i    (minor),
        .tval_i     (tval_q),
        .tval2_i    (tval2_q),
        .tinst_i    (tinst_q),
        .tval_wr_i  (tval_wr_q),
        .tval2_wr_i (tval2_wr_q),
        .tinst_wr_i (tinst_wr_q),
        .sp_i       (sp_q),
        .epc_i      (epc_q),
        .pistatus_i (pistatus_q),
        .load_o     (load),
        .rf_we_o    (rf_we_o),
        .rf_addr_o  (rf_addr_o),
        .rf_data_o  (rf_data_o),
        .st_en_o    (st_en_o),
        .st_addr_o  (st_addr_o),
        .st_data_o  (st_data_o),
        .ie_set_o   (ie_set_o),
        .done_o     (done_o)
    );

endmodule

// File: tb/test_trap_argwb_seq.sv
module test_trap_argwb_seq;

    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, start;
    logic [DW-1:0] cause, tval, tval2, tinst, topi, topei, sp, epc, pis;
    logic          tval_wr, tval2_wr, tinst_wr;
    logic          rf_we, st_en, ie_set, done;
    logic [4:0]    rf_addr;
    logic [DW-1:0] rf_data, st_addr, st_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    int            e_kind [8];
    logic [DW-1:0] e_addr [8];
    logic [DW-1:0] e_data [8];
    string         e_req  [8];
    int            n_ops;

    trap_argwb_seq i_trap_argwb_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cause_i(cause), .tval_i(tval), .tval2_i(tval2), .tinst_i(tinst),
        .tval_wr_i(tval_wr), .tval2_wr_i(tval2_wr), .tinst_wr_i(tinst_wr),
        .topi_i(topi), .topei_i(topei), .sp_i(sp), .epc_i(epc), .pistatus_i(pis),
        .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_data_o(rf_data),
        .st_en_o(st_en), .st_addr_o(st_addr), .st_data_o(st_data),
        .ie_set_o(ie_set), .done_o(done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog: got no finish, expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic add_op(input int k, input logic [DW-1:0] a, input logic [DW-1:0] d,
                          input string r);
        e_kind[n_ops] = k;
        e_addr[n_ops] = a;
        e_data[n_ops] = d;
        e_req[n_ops]  = r;
        n_ops++;
    endtask

    // Expected sequence from the requirements (kind 0 store, 1 write, 2 finish)
    task automatic plan_seq();
        logic [DW-1:0] maj, mnr;
        n_ops = 0;
        add_op(0, sp + 32'd24, epc, "R2");
        add_op(0, sp + 32'd28, pis, "R2");
        if (!cause[DW-1]) begin
            add_op(1, 32'd10, cause, "R3");
            if (tval_wr)  add_op(1, 32'd11, tval,  "R3");
            if (tval2_wr) add_op(1, 32'd12, tval2, "R3");
            if (tinst_wr) add_op(1, 32'd13, tinst, "R3");
        end else begin
            maj = topi >> 16;
            mnr = topei >> 16;
            if (maj == 32'd11) begin
                add_op(1, 32'd10, maj, "R6");
                add_op(1, 32'd11, mnr, "R6");
            end else begin
                add_op(1, 32'd10, maj, "R5");  // also R4: sign bit selects interrupt
            end
        end
        add_op(2, '0, '0, "R7");
    endtask

    task automatic scramble();
        cause = $urandom; tval = $urandom; tval2 = $urandom; tinst = $urandom;
        topi = $urandom; topei = $urandom; sp = $urandom; epc = $urandom; pis = $urandom;
        tval_wr = 1'($urandom); tval2_wr = 1'($urandom); tinst_wr = 1'($urandom);
    endtask

    task automatic check_idle(input string r);
        n_chk++;
        if (rf_we || st_en || ie_set || done) begin
            n_err++;
            $display("FAIL %s idle: got we=%b st=%b ie=%b done=%b, expected all 0",
                     r, rf_we, st_en, ie_set, done);
        end
    endtask

    task automatic check_op(input int i);
        logic ok;
        ok = 1'b1;
        unique case (e_kind[i])
            0: ok = st_en && !rf_we && !ie_set && !done &&
                    st_addr == e_addr[i] && st_data == e_data[i];
            1: ok = rf_we && !st_en && !ie_set && !done &&
                    rf_addr == e_addr[i][4:0] && rf_data == e_data[i];
            default: ok = done && ie_set && !rf_we && !st_en;
        endcase
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s op%0d: got st=%b sa=%h sd=%h we=%b ra=%0d rd=%h ie=%b done=%b, expected kind=%0d addr=%h data=%h",
                     e_req[i], i, st_en, st_addr, st_data, rf_we, rf_addr, rf_data,
                     ie_set, done, e_kind[i], e_addr[i], e_data[i]);
        end
    endtask

    // Called at a negedge with inputs set; noise exercises R9 and the capture part of R2
    task automatic run_case(input bit noise);
        plan_seq();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n_ops; i++) begin
            if (noise) scramble();
            check_op(i);
            if (noise && i < n_ops - 1) start = 1'($urandom);
            else start = 1'b0;
            @(negedge clk);
        end
        check_idle("R7");
    endtask

    task automatic set_exc(input logic [DW-1:0] c, input bit f1, input bit f2, input bit f3);
        scramble();
        cause = c; cause[DW-1] = 1'b0;
        tval_wr = f1; tval2_wr = f2; tinst_wr = f3;
    endtask

    task automatic set_irq(input logic [15:0] id, input logic [DW-1:0] c);
        scramble();
        cause = c; cause[DW-1] = 1'b1;
        topi = {id, 16'($urandom) | 16'h00ff};
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; start = 1'b0;
        scramble();
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R3 directed: no flags, all flags, only trapped instruction, largest exception cause
        set_exc(32'h0000_0005, 1'b0, 1'b0, 1'b0); run_case(1'b0);
        set_exc(32'h0000_000d, 1'b1, 1'b1, 1'b1); run_case(1'b0);
        set_exc(32'h0000_0002, 1'b0, 1'b0, 1'b1); run_case(1'b0);
        set_exc(32'h7fff_ffff, 1'b0, 1'b1, 1'b0); run_case(1'b0);
        // R4: only the sign bit set
        set_irq(16'd3, 32'h8000_0000); run_case(1'b0);
        // R6 boundary at 11, R5 neighbours 10 and 12
        set_irq(16'd11, 32'h8000_000b); run_case(1'b0);
        set_irq(16'd10, 32'h8000_000a); run_case(1'b0);
        set_irq(16'd12, 32'hffff_ffff); run_case(1'b0);
        // R9: starts and input changes while busy
        set_irq(16'd11, 32'h8000_0001); run_case(1'b1);
        set_exc(32'h0000_0007, 1'b1, 1'b0, 1'b1); run_case(1'b1);

        for (int n = 0; n < 400; n++) begin
            scramble();
            if (cause[DW-1] && ($urandom % 3 == 0)) topi[31:16] = 16'd11;
            else if (cause[DW-1]) topi[31:16] = 16'($urandom % 64);
            run_case(1'($urandom));
            if ($urandom % 4 == 0) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule